// File: doc/BRIEF.md
# Timer Run and External Interrupt Flag Register

This block is the 8-bit control and status byte that sits between a small CPU core, two timer counters and the interrupt controller. Software uses it to start and stop each timer and to choose, for each of two active-low external request pins, whether the request is a falling edge or a low level. Hardware uses it to record that a timer has wrapped around or that an external pin has asked for service. It drives the run enables to the timers and one request line per source toward the interrupt controller.

The CPU can load the whole byte in one write or set or clear a single bit by its index. Each timer overflow pulse sets its flag, and each acknowledge pulse from the interrupt controller clears the flag of the source being serviced. Each external pin passes through a two-flop synchronizer. In edge mode a falling edge latches the request flag. In level mode the flag simply follows the inverted synchronized pin and cannot be written. A hardware set event always beats a clear that arrives in the same cycle. Reset is asynchronous on assertion and is released on a clock edge inside the block.

Top module: `tmr_xint_ctl`

## Requirements
- R1: After reset the register reads 0x00, and every run and request output is 0 while the pins are high.
- R2: Bit positions from bit 7 down to bit 0 are: timer-1 overflow, timer-1 run, timer-0 overflow, timer-0 run, pin-1 flag, pin-1 mode, pin-0 flag, pin-0 mode. A whole-byte write loads every bit, except a flag whose mode bit was 0 before the write. The new value reads back after one clock edge.
- R3: A single-bit write puts `bit_val` into the bit whose index is `bit_sel`, with 0 being the LSB. When a byte write and a single-bit write happen in the same cycle, the single-bit value wins for the selected bit.
- R4: Each `tmr_run` output equals its timer's run bit. A 0 halts the timer and a 1 lets it count.
- R5: A one-cycle `tmr_ovf` pulse sets that timer's overflow flag at the next clock edge.
- R6: A `tmr_ack` pulse clears that timer's overflow flag. Software can set and clear the overflow flag with either write form.
- R7: In edge mode (mode bit 1), a falling edge on a pin sets its flag on the third clock edge after the pin changes. A rising edge does not clear the flag, so it stays set.
- R8: In edge mode the flag is cleared by its `xint_ack` pulse or by a software write of 0. Software can also set it.
- R9: In level mode (mode bit 0), the flag equals the inverse of the pin as it was three clock edges earlier. Software writes and acknowledge pulses do not change it.
- R10: A hardware set event (an overflow pulse or a detected falling edge) wins over a software clear or an acknowledge in the same cycle.
- R11: `tmr_irq[i]` equals the overflow flag of timer i, and `xint_irq[i]` equals the flag of pin i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_byte_en | input | 1 | Whole-byte write strobe |
| wr_data | input | 8 | Byte write data |
| bit_wr_en | input | 1 | Single-bit write strobe |
| bit_sel | input | 3 | Index of the bit to write |
| bit_val | input | 1 | Value for the single-bit write |
| tmr_ovf | input | 2 | Overflow pulses, one per timer |
| tmr_ack | input | 2 | Timer interrupt acknowledge pulses |
| xint_pin | input | 2 | Raw active-low external request pins |
| xint_ack | input | 2 | External interrupt acknowledge pulses |
| reg_rdata | output | 8 | Register readback |
| tmr_run | output | 2 | Run enables to the timers |
| tmr_irq | output | 2 | Timer interrupt requests |
| xint_irq | output | 2 | External interrupt requests |

## Verification
The hardest cases to reach are those where a detected falling edge lands in exactly the same cycle as an acknowledge and a software clear. The edge only appears after two synchronizer stages, so the acknowledge has to be timed to that cycle. The bench drives the pin low on a falling clock edge, counts two rising edges, and then raises the acknowledge and the single-bit clear together for one cycle. A second hard case is a mode change that lands on the same edge as a flag write. The sweeps write each value twice so that the new mode has settled before the readback is compared with a value computed from the written byte.

// File: rtl/tmr_xint_pkg.sv
package tmr_xint_pkg;

  localparam int SYNC_STAGES = 2;

  // Layout: external channels in the low half, timers in the high half.
  function automatic int xint_mode_bit(input int ch);
    return 2 * ch;
  endfunction

  function automatic int xint_flag_bit(input int ch);
    return 2 * ch + 1;
  endfunction

  function automatic int tmr_run_bit(input int nch, input int ch);
    return 2 * nch + 2 * ch;
  endfunction

  function automatic int tmr_ovf_bit(input int nch, input int ch);
    return 2 * nch + 2 * ch + 1;
  endfunction

endpackage

// File: rtl/txc_rst_sync.sv
module txc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/txc_pin_edge.sv
module txc_pin_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic fall
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
  end

  // Idle level of an active-low pin is 1, so reset to 1 to avoid a false edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl  = sync_q[STAGES-1];
  assign fall = prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/txc_tmr_chan.sv
module txc_tmr_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_we,
  input  logic ovf_wv,
  input  logic run_we,
  input  logic run_wv,
  input  logic ovf_pulse,
  input  logic ack,
  output logic ovf_q,
  output logic run_q
);

  logic ovf_d;
  logic ovf_en;

  always_comb begin
    ovf_en = ovf_pulse | ack | ovf_we;
    if (ovf_pulse) begin
      ovf_d = 1'b1;
    end else if (ack) begin
      ovf_d = 1'b0;
    end else begin
      ovf_d = ovf_wv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      if (ovf_en) ovf_q <= ovf_d;
      if (run_we) run_q <= run_wv;
    end
  end

endmodule

// File: rtl/txc_xint_chan.sv
module txc_xint_chan
  import tmr_xint_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic flag_we,
  input  logic flag_wv,
  input  logic mode_we,
  input  logic mode_wv,
  input  logic ack,
  output logic flag_q,
  output logic mode_q
);

  logic lvl;
  logic fall;
  logic flag_d;
  logic flag_en;

  txc_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (pin),
    .lvl  (lvl),
    .fall (fall)
  );

  always_comb begin
    if (!mode_q) begin
      flag_en = 1'b1;
      flag_d  = ~lvl;
    end else begin
      flag_en = fall | ack | flag_we;
      if (fall) begin
        flag_d = 1'b1;
      end else if (ack) begin
        flag_d = 1'b0;
      end else begin
        flag_d = flag_wv;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (flag_en) flag_q <= flag_d;
      if (mode_we) mode_q <= mode_wv;
    end
  end

endmodule

// File: rtl/tmr_xint_ctl.sv
module tmr_xint_ctl
  import tmr_xint_pkg::*;
#(
  parameter  int NUM_CH = 2,
  localparam int REG_W  = 4 * NUM_CH,
  localparam int SEL_W  = $clog2(REG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_byte_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              bit_wr_en,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic              bit_val,
  input  logic [NUM_CH-1:0] tmr_ovf,
  input  logic [NUM_CH-1:0] tmr_ack,
  input  logic [NUM_CH-1:0] xint_pin,
  input  logic [NUM_CH-1:0] xint_ack,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0] tmr_run,
  output logic [NUM_CH-1:0] tmr_irq,
  output logic [NUM_CH-1:0] xint_irq
);

  logic              rst_sync_n;
  logic [REG_W-1:0]  sw_we;
  logic [REG_W-1:0]  sw_val;
  logic [NUM_CH-1:0] t_ovf;
  logic [NUM_CH-1:0] t_run;
  logic [NUM_CH-1:0] x_flag;
  logic [NUM_CH-1:0] x_mode;

  txc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  // Per-bit software write decode; a single-bit write overrides the byte value.
  for (genvar b = 0; b < REG_W; b++) begin : g_dec
    logic hit;
    assign hit       = bit_wr_en && (bit_sel == SEL_W'(b));
    assign sw_we[b]  = wr_byte_en | hit;
    assign sw_val[b] = hit ? bit_val : wr_data[b];
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    txc_tmr_chan u_tmr (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .ovf_we   (sw_we[tmr_ovf_bit(NUM_CH, c)]),
      .ovf_wv   (sw_val[tmr_ovf_bit(NUM_CH, c)]),
      .run_we   (sw_we[tmr_run_bit(NUM_CH, c)]),
      .run_wv   (sw_val[tmr_run_bit(NUM_CH, c)]),
      .ovf_pulse(tmr_ovf[c]),
      .ack      (tmr_ack[c]),
      .ovf_q    (t_ovf[c]),
      .run_q    (t_run[c])
    );

    txc_xint_chan u_xint (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .pin    (xint_pin[c]),
      .flag_we(sw_we[xint_flag_bit(c)]),
      .flag_wv(sw_val[xint_flag_bit(c)]),
      .mode_we(sw_we[xint_mode_bit(c)]),
      .mode_wv(sw_val[xint_mode_bit(c)]),
      .ack    (xint_ack[c]),
      .flag_q (x_flag[c]),
      .mode_q (x_mode[c])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      reg_rdata[tmr_ovf_bit(NUM_CH, c)] = t_ovf[c];
      reg_rdata[tmr_run_bit(NUM_CH, c)] = t_run[c];
      reg_rdata[xint_flag_bit(c)]       = x_flag[c];
      reg_rdata[xint_mode_bit(c)]       = x_mode[c];
    end
  end

  assign tmr_run  = t_run;
  assign tmr_irq  = t_ovf;
  assign xint_irq = x_flag;

endmodule

// File: rtl/txc_chk.sv
module txc_chk #(
  parameter  int NUM_CH = 2,
  localparam int REG_W  = 4 * NUM_CH,
  localparam int SEL_W  = $clog2(REG_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ovf0_rd,
  input logic             ovfl_rd,
  input logic             mode0_rd,
  input logic             flag0_rd,
  input logic             ovf0_in,
  input logic             ovfl_in,
  input logic             ack0_in,
  input logic             run0_out,
  input logic             pin0_in,
  input logic             wr_byte_en,
  input logic             wr_run0,
  input logic             bit_wr_en,
  input logic [SEL_W-1:0] bit_sel,
  input logic             bit_val
);

  localparam logic [SEL_W-1:0] RUN0_IDX = SEL_W'(2 * NUM_CH);
  localparam logic [SEL_W-1:0] OVFL_IDX = SEL_W'(4 * NUM_CH - 1);

  logic [2:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_q != 3'd4) begin
      age_q <= age_q + 3'd1;
    end
  end

  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf0_in |=> ovf0_rd);

  // R6
  ovf_ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack0_in && !ovf0_in) |=> !ovf0_rd);

  // R10
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfl_in && bit_wr_en && bit_sel == OVFL_IDX && !bit_val) |=> ovfl_rd);

  // R3
  run_bit_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr_en && bit_sel == RUN0_IDX) |=> (run0_out == $past(bit_val)));

  // R2
  run_byte_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_byte_en && !bit_wr_en) |=> (run0_out == $past(wr_run0)));

  // R9
  level_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 3'd4 && !mode0_rd) |=> (flag0_rd == !$past(pin0_in, 3)));

endmodule

bind tmr_xint_ctl txc_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .ovf0_rd   (reg_rdata[2*NUM_CH+1]),
  .ovfl_rd   (reg_rdata[4*NUM_CH-1]),
  .mode0_rd  (reg_rdata[0]),
  .flag0_rd  (reg_rdata[1]),
  .ovf0_in   (tmr_ovf[0]),
  .ovfl_in   (tmr_ovf[NUM_CH-1]),
  .ack0_in   (tmr_ack[0]),
  .run0_out  (tmr_run[0]),
  .pin0_in   (xint_pin[0]),
  .wr_byte_en(wr_byte_en),
  .wr_run0   (wr_data[2*NUM_CH]),
  .bit_wr_en (bit_wr_en),
  .bit_sel   (bit_sel),
  .bit_val   (bit_val)
);

// File: tb/tmr_xint_ctl_test.sv
module tmr_xint_ctl_test;

  logic       clk;
  logic       rst_n;
  logic       wr_byte_en;
  logic [7:0] wr_data;
  logic       bit_wr_en;
  logic [2:0] bit_sel;
  logic       bit_val;
  logic [1:0] tmr_ovf;
  logic [1:0] tmr_ack;
  logic [1:0] xint_pin;
  logic [1:0] xint_ack;
  logic [7:0] reg_rdata;
  logic [1:0] tmr_run;
  logic [1:0] tmr_irq;
  logic [1:0] xint_irq;

  int n_chk;
  int n_fail;
  bit done;

  tmr_xint_ctl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_byte_en(wr_byte_en),
    .wr_data   (wr_data),
    .bit_wr_en (bit_wr_en),
    .bit_sel   (bit_sel),
    .bit_val   (bit_val),
    .tmr_ovf   (tmr_ovf),
    .tmr_ack   (tmr_ack),
    .xint_pin  (xint_pin),
    .xint_ack  (xint_ack),
    .reg_rdata (reg_rdata),
    .tmr_run   (tmr_run),
    .tmr_irq   (tmr_irq),
    .xint_irq  (xint_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic byte_wr(input logic [7:0] v);
    wr_byte_en = 1'b1;
    wr_data    = v;
    step();
    wr_byte_en = 1'b0;
  endtask

  task automatic bit_wr(input int b, input logic v);
    bit_wr_en = 1'b1;
    bit_sel   = 3'(b);
    bit_val   = v;
    step();
    bit_wr_en = 1'b0;
  endtask

  // Settled readback of a byte written with both pins high.
  function automatic logic [7:0] settle(input logic [7:0] v);
    logic [7:0] r;
    r = v;
    if (!v[0]) r[1] = 1'b0;
    if (!v[2]) r[3] = 1'b0;
    return r;
  endfunction

  function automatic logic [7:0] after_bit(input logic [7:0] s, input int b, input logic v);
    logic [7:0] r;
    r    = s;
    r[b] = v;
    if (!s[0]) r[1] = 1'b0;
    if (!s[2]) r[3] = 1'b0;
    return r;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] s;
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; wr_byte_en = 1'b0; wr_data = '0; bit_wr_en = 1'b0;
    bit_sel = '0; bit_val = 1'b0; tmr_ovf = '0; tmr_ack = '0;
    xint_pin = 2'b11; xint_ack = '0;
    steps(3);
    chk("R1 reset", reg_rdata, 8'h00);
    rst_n = 1'b1;
    steps(5);
    chk("R1 after release", reg_rdata, 8'h00);
    chk("R1 outputs", {2'b00, tmr_run, tmr_irq, xint_irq}, 8'h00);

    // R5 / R6 timer flag
    tmr_ovf[0] = 1'b1; step(); tmr_ovf[0] = 1'b0;
    chk("R5 ovf set", reg_rdata, 8'h20);
    chk("R11 tmr_irq", {6'd0, tmr_irq}, 8'h01);
    tmr_ack[0] = 1'b1; step(); tmr_ack[0] = 1'b0;
    chk("R6 ack clear", reg_rdata, 8'h00);
    bit_wr(7, 1'b1);
    chk("R6 sw set", reg_rdata, 8'h80);
    bit_wr(7, 1'b0);
    chk("R6 sw clear", reg_rdata, 8'h00);

    // R10 collisions on timer flags
    tmr_ovf[1] = 1'b1; bit_wr_en = 1'b1; bit_sel = 3'd7; bit_val = 1'b0;
    step();
    tmr_ovf[1] = 1'b0; bit_wr_en = 1'b0;
    chk("R10 set beats sw clear", reg_rdata, 8'h80);
    tmr_ovf[0] = 1'b1; tmr_ack[0] = 1'b1; step();
    tmr_ovf[0] = 1'b0; tmr_ack[0] = 1'b0;
    chk("R10 set beats ack", reg_rdata, 8'hA0);
    byte_wr(8'h00);

    // R3 single bit beats byte write
    wr_byte_en = 1'b1; wr_data = 8'h00; bit_wr_en = 1'b1; bit_sel = 3'd6; bit_val = 1'b1;
    step();
    wr_byte_en = 1'b0; bit_wr_en = 1'b0;
    chk("R3 bit over byte", reg_rdata, 8'h40);
    chk("R4 run out", {6'd0, tmr_run}, 8'h02);
    byte_wr(8'h00);

    // R7 edge mode latch and latency
    byte_wr(8'h01);
    xint_pin[0] = 1'b0;
    step();
    chk("R7 edge +1", reg_rdata, 8'h01);
    step();
    chk("R7 edge +2", reg_rdata, 8'h01);
    step();
    chk("R7 edge +3", reg_rdata, 8'h03);
    chk("R11 xint_irq", {6'd0, xint_irq}, 8'h01);
    xint_pin[0] = 1'b1;
    steps(4);
    chk("R7 rise keeps flag", reg_rdata, 8'h03);

    // R8 clears and software set
    xint_ack[0] = 1'b1; step(); xint_ack[0] = 1'b0;
    chk("R8 ack clear", reg_rdata, 8'h01);
    bit_wr(1, 1'b1);
    chk("R8 sw set", reg_rdata, 8'h03);
    bit_wr(1, 1'b0);
    chk("R8 sw clear", reg_rdata, 8'h01);
    xint_pin[0] = 1'b0; steps(3);
    chk("R7 second edge", reg_rdata, 8'h03);
    xint_pin[0] = 1'b1;
    byte_wr(8'h01);
    chk("R8 byte clear", reg_rdata, 8'h01);
    steps(3);

    // R10 edge versus ack and software clear in the same cycle
    xint_pin[0] = 1'b0; steps(2);
    xint_ack[0] = 1'b1; bit_wr_en = 1'b1; bit_sel = 3'd1; bit_val = 1'b0;
    step();
    xint_ack[0] = 1'b0; bit_wr_en = 1'b0;
    chk("R10 edge beats ack", reg_rdata, 8'h03);
    xint_pin[0] = 1'b1; steps(3);
    xint_ack[0] = 1'b1; step(); xint_ack[0] = 1'b0;
    chk("R8 ack after collision", reg_rdata, 8'h01);

    // R9 level mode on pin 1
    xint_pin[1] = 1'b0; steps(2);
    chk("R9 level +2", reg_rdata, 8'h01);
    step();
    chk("R9 level +3", reg_rdata, 8'h09);
    chk("R11 xint_irq level", {6'd0, xint_irq}, 8'h02);
    byte_wr(8'h01);
    chk("R9 byte write ignored", reg_rdata, 8'h09);
    xint_ack[1] = 1'b1; step(); xint_ack[1] = 1'b0;
    chk("R9 ack ignored", reg_rdata, 8'h09);
    bit_wr(3, 1'b0);
    chk("R9 bit clear ignored", reg_rdata, 8'h09);
    xint_pin[1] = 1'b1; steps(2);
    chk("R9 release +2", reg_rdata, 8'h09);
    step();
    chk("R9 release +3", reg_rdata, 8'h01);
    bit_wr(3, 1'b1);
    chk("R9 bit set ignored", reg_rdata, 8'h01);
    byte_wr(8'h09);
    chk("R9 byte set ignored", reg_rdata, 8'h01);

    // R2 / R4 / R11 sweep of every byte value
    for (int v = 0; v < 256; v++) begin
      byte_wr(8'(v));
      byte_wr(8'(v));
      s = settle(8'(v));
      chk("R2 byte sweep", reg_rdata, s);
      chk("R4 run sweep", {6'd0, tmr_run}, {6'd0, s[6], s[4]});
      chk("R11 irq sweep", {4'd0, tmr_irq, xint_irq}, {4'd0, s[7], s[5], s[3], s[1]});
    end

    // R3 sweep of every bit index and value from two start states
    for (int st = 0; st < 2; st++) begin
      for (int b = 0; b < 8; b++) begin
        for (int v = 0; v < 2; v++) begin
          s = (st == 0) ? 8'h55 : 8'hAA;
          byte_wr(s);
          byte_wr(s);
          s = settle(s);
          bit_wr(b, v[0]);
          chk("R3 bit sweep", reg_rdata, after_bit(s, b, v[0]));
        end
      end
    end

    done = 1'b1;
    finish_run();
  end

endmodule